// File: doc/BRIEF.md
# Push-Button Single-Pulse Generator

This block turns one press of a mechanical push-button into exactly one clean, single-cycle enable pulse in the system clock domain. The raw button level first goes through a two-stage synchronizer. A rising edge on the synchronized level wakes a two-state controller. The controller leaves its idle state, raises a run flag and emits one pulse.

While the run flag is high, further button edges are ignored. This absorbs contact bounce. An internal lockout timer starts when the run flag rises. After a parameterized number of cycles it issues a one-cycle stop strobe. The controller detects the rising edge of that strobe and goes back to idle. A button that is still held at that moment does not retrigger. Only a new release-and-press can start another run. Downstream logic uses the pulse as its clock enable.

Top module: `btn_pulse_gen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) drives run_o and pulse_o low after that edge and clears the lockout count, so the next accepted press gives a run of the full LOCK_CYCLES length.
- R2: btn_i passes through a two-stage synchronizer. If btn_i is low at edge k-1 and high at edge k while idle, pulse_o and run_o are first high after edge k+2 and still low after edge k+1.
- R3: pulse_o is high for exactly one cycle for each accepted press, in the first cycle in which run_o is high.
- R4: Once raised, run_o stays high for exactly LOCK_CYCLES cycles and then falls. An internal single-cycle stop strobe from the lockout timer ends the run.
- R5: Rising edges of btn_i whose synchronized value arrives while run_o is high are ignored: they give no pulse and do not lengthen the run.
- R6: A button still held when the run ends produces no new pulse until it is released and pressed again.
- R7: A fresh rising edge whose synchronized value arrives in the first idle cycle after a run is accepted and starts a new run.
- R8: A btn_i held low produces no pulse and no run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_i | input | 1 | Raw, asynchronous push-button level, active high |
| run_o | output | 1 | High while a press is being served and the lockout runs |
| pulse_o | output | 1 | One-cycle clean pulse per accepted press |

## Verification
A controller stuck in the running state shows at the ports as run_o high for longer than LOCK_CYCLES and as missing pulses on later presses. Both appear within one lockout period. A controller that does not block edges while running shows as extra pulses from a bouncing pattern within three cycles of the second edge. An off-by-one in the lockout count, or a count that reset fails to clear, changes the measured run length by at least one cycle. The bench counts run cycles per press, so it sees this on the first run after the fault. Presses that land one cycle before and exactly at the first idle cycle check the boundary between ignoring an edge and accepting it.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bpg_state_e;
endpackage

// File: rtl/bpg_sync.sv
module bpg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], din};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign level_o = s_q.chain[STAGES-1];
    assign rise_o  = s_q.chain[STAGES-1] & ~s_q.prev;

    // R2: an edge report lasts one cycle only
    p_rise_single_r2: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/bpg_lockout.sv
module bpg_lockout #(
    parameter int LOCK_CYCLES = 1 << 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic stop_o
);
    localparam int CW = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } lock_t;

    lock_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (run_i && (l_q.cnt != LAST)) l_d.cnt = l_q.cnt + 1'b1;
        else                            l_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) l_q <= '0;
        else     l_q <= l_d;
    end

    assign stop_o = run_i && (l_q.cnt == LAST);

    p_stop_single_r4: assert property (@(posedge clk) disable iff (rst)
        stop_o |=> !stop_o);
    p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
        l_q.cnt <= LAST);
endmodule

// File: rtl/bpg_ctrl.sv
module bpg_ctrl
    import bpg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic btn_rise_i,
    input  logic stop_i,
    output logic run_o,
    output logic pulse_o
);
    typedef struct packed {
        bpg_state_e st;
        logic       pulse;
        logic       stop_prev;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  stop_rise;

    assign stop_rise = stop_i & ~c_q.stop_prev;

    always_comb begin
        c_d           = c_q;
        c_d.pulse     = 1'b0;
        c_d.stop_prev = stop_i;
        unique case (c_q.st)
            ST_IDLE: begin
                if (btn_rise_i) begin
                    c_d.st    = ST_RUN;
                    c_d.pulse = 1'b1;
                end
            end
            ST_RUN: begin
                if (stop_rise) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '{st: ST_IDLE, pulse: 1'b0, stop_prev: 1'b0};
        else     c_q <= c_d;
    end

    assign run_o   = (c_q.st == ST_RUN);
    assign pulse_o = c_q.pulse;

    p_pulse_entry_r3: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> (run_o && $past(c_q.st) == ST_IDLE));
    p_accept_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == ST_IDLE && btn_rise_i) |=> pulse_o);
    p_hold_run_r5: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == ST_RUN && !stop_rise) |=> (run_o && !pulse_o));
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (c_q.st == ST_IDLE && !btn_rise_i) |=> !run_o);
endmodule

// File: rtl/btn_pulse_gen.sv
module btn_pulse_gen #(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_CYCLES = 1 << 20
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_i,
    output logic run_o,
    output logic pulse_o
);
    logic btn_level;
    logic btn_rise;
    logic stop;
    logic run;

    bpg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .din     (btn_i),
        .level_o (btn_level),
        .rise_o  (btn_rise)
    );

    bpg_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .stop_o (stop)
    );

    bpg_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .btn_rise_i (btn_rise),
        .stop_i     (stop),
        .run_o      (run),
        .pulse_o    (pulse_o)
    );

    assign run_o = run;

    // R6: a steady held level cannot start a run
    p_held_no_start_r6: assert property (@(posedge clk) disable iff (rst)
        (!run && $past(btn_level) && btn_level) |=> !pulse_o);
endmodule

// File: tb/test_btn_pulse_gen.sv
`timescale 1ns/1ps
module test_btn_pulse_gen;
    localparam int LOCK = 8;
    localparam int NVEC = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_i = 1'b0;
    logic run_o, pulse_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    btn_pulse_gen #(.SYNC_STAGES(2), .LOCK_CYCLES(LOCK)) i_btn_pulse_gen (
        .clk     (clk),
        .rst     (rst),
        .btn_i   (btn_i),
        .run_o   (run_o),
        .pulse_o (pulse_o)
    );

    typedef struct packed {
        logic [15:0] pat;
        logic [7:0]  npulse;
        logic [7:0]  nrun;
    } vec_t;

    // pattern bit c drives btn_i at edge c of the window
    localparam vec_t VECS [NVEC] = '{
        '{16'h0000, 8'd0, 8'd0},   // R8 button idle
        '{16'h0001, 8'd1, 8'd8},   // R2 one-cycle press
        '{16'h0055, 8'd1, 8'd8},   // R5 bouncing press
        '{16'hFFFF, 8'd1, 8'd8},   // R6 held past end of run
        '{16'h1001, 8'd2, 8'd16},  // R7 re-press well after run
        '{16'h0201, 8'd2, 8'd16},  // R7 re-press lands on first idle cycle
        '{16'h0101, 8'd1, 8'd8}    // R5 re-press lands on last run cycle
    };
    localparam string TAGS [NVEC] = '{"R8", "R2", "R5", "R6", "R7", "R7", "R5"};

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_window(input logic [15:0] pat, output int np, output int nr, output int dbl);
        logic last_p;
        np = 0; nr = 0; dbl = 0; last_p = 1'b0;
        for (int c = 0; c < 40; c++) begin
            btn_i = (c < 16) ? pat[c] : 1'b0;
            @(negedge clk);
            if (pulse_o) np++;
            if (run_o) nr++;
            if (pulse_o && last_p) dbl++;
            last_p = pulse_o;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int np, nr, dbl;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", run_o, 0, "run_o in reset");
        check("R1", pulse_o, 0, "pulse_o in reset");
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            run_window(VECS[v].pat, np, nr, dbl);
            check(TAGS[v], np, int'(VECS[v].npulse), $sformatf("pulses vec%0d", v));
            check(TAGS[v], nr, int'(VECS[v].nrun), $sformatf("run cycles vec%0d", v));
            check("R3", dbl, 0, $sformatf("back-to-back pulses vec%0d", v));
        end

        // R2 latency: btn_i high at edge k
        btn_i = 1'b1;
        @(negedge clk);                 // after edge k
        check("R2", pulse_o, 0, "pulse after k");
        @(negedge clk);                 // after edge k+1
        check("R2", pulse_o, 0, "pulse after k+1");
        check("R2", run_o, 0, "run after k+1");
        @(negedge clk);                 // after edge k+2
        check("R2", pulse_o, 1, "pulse after k+2");
        check("R3", run_o, 1, "run with pulse");
        @(negedge clk);                 // after edge k+3
        check("R3", pulse_o, 0, "pulse after k+3");
        btn_i = 1'b0;

        // R1 reset in mid-run, then a full-length run
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", run_o, 0, "run_o after mid-run reset");
        check("R1", pulse_o, 0, "pulse_o after mid-run reset");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        run_window(16'h0001, np, nr, dbl);
        check("R1", np, 1, "pulses after reset");
        check("R4", nr, LOCK, "run length after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule